// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a single-clock request port to an external asynchronous static RAM with 131072 bytes. A client presents a read or a write with a 17-bit address and, for writes, one data byte. The block drives the memory's two chip enables, write strobe and read strobe, and it owns the FPGA side of the shared 8-bit data bus. It finishes each transfer with a one-cycle done pulse, and that pulse carries the captured byte when the transfer is a read.

The memory has no clock, so every timing limit is given in nanoseconds. Parameters convert each limit to a whole number of clock cycles, always rounding up and never going below one cycle. A read holds the address and keeps the read strobe low for long enough to cover address access time, strobe access time and the minimum cycle. A write first waits until the memory has released the bus. It then pulses the write strobe with data driven for the pulse-width and data-setup minimums, and it keeps the chip selected for the full write cycle. Between transfers the chip is deselected, which puts it in its low-power standby state.

Top module: `sram_async_ctrl`

## Requirements
- R1: In reset and whenever `req_ready` is high, the memory is deselected: `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1 and `bus_drive`=0.
- R2: A read keeps `mem_sel_n`=0, `mem_sel`=1 and `mem_wr_n`=1, and holds `mem_rd_n` low for at least max(T_AA, T_DOE, T_RC) ns. The byte returned equals the byte last written to that address, or 00 if the address was never written.
- R3: `req_ready` is high exactly when the chip is deselected. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R4: `rsp_valid` pulses for exactly one cycle per accepted request. For a read it comes RD_CYC+1 cycles after acceptance, with RD_CYC = ceil(max(T_AA, T_DOE, T_RC)/CLK_NS).
- R5: During a write, `mem_wr_n` stays low for at least T_PWE ns with the chip selected. The byte stored is `req_wdata`.
- R6: `bus_drive` is high for at least T_SD ns before `mem_wr_n` rises, and it falls on the same edge on which `mem_wr_n` rises.
- R7: `bus_drive` rises only after `mem_rd_n` has been high for at least T_HZ ns. This holds when a write follows a read directly.
- R8: `bus_drive` and `mem_wr_n` are never asserted while `mem_rd_n` is low.
- R9: The address stays unchanged while the chip is selected. Each selected period lasts at least T_WC ns for a write and at least T_RC ns for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request may be accepted |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| bus_drive | output | 1 | Enables the FPGA-side data bus driver |
| mem_dq_in | input | 8 | Byte sampled from the data bus |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |

## Verification
A phase counter that ends early shortens a strobe, and the bench sees this at the next strobe edge. A short read returns the model's filler byte in that same transfer. A short write pulse or a short data setup is reported at the rising edge of the write strobe. A wrong state decode leaves the chip selected or a strobe low after the done pulse. It can also turn the bus driver on too soon after a read, and both show up within a cycle of the event. A wrong address or byte path gives a read-back mismatch against the bench's reference map on the next read of that location.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 20,
  parameter int T_RC   = 45,
  parameter int T_AA   = 45,
  parameter int T_DOE  = 22,
  parameter int T_WC   = 45,
  parameter int T_PWE  = 35,
  parameter int T_SD   = 25,
  parameter int T_HZ   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              bus_drive,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = imax(imax(to_cyc(T_AA), to_cyc(T_DOE)), to_cyc(T_RC));
  localparam int PW_CYC  = imax(to_cyc(T_PWE), to_cyc(T_SD));
  localparam int REC_CYC = imax(1, to_cyc(T_WC) - PW_CYC - 1);
  localparam int HZ_CYC  = to_cyc(T_HZ);
  localparam int CNT_W   = $clog2(imax(imax(RD_CYC, PW_CYC), REC_CYC) + 1);
  localparam int HZ_W    = $clog2(HZ_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WTURN, S_WPULSE, S_WREC} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [HZ_W-1:0]   rd_hi_cnt;

  assign req_ready = (state == S_IDLE);
  assign mem_sel   = ~mem_sel_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      rd_hi_cnt  <= '0;
      mem_sel_n  <= 1'b1;
      mem_wr_n   <= 1'b1;
      mem_rd_n   <= 1'b1;
      bus_drive  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!mem_rd_n)
        rd_hi_cnt <= '0;
      else if (rd_hi_cnt != HZ_W'(HZ_CYC))
        rd_hi_cnt <= rd_hi_cnt + HZ_W'(1);
      unique case (state)
        S_IDLE: if (req_valid) begin
          mem_addr  <= req_addr;
          mem_sel_n <= 1'b0;
          if (req_write) begin
            mem_dq_out <= req_wdata;
            state      <= S_WTURN;
          end else begin
            mem_rd_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            state    <= S_READ;
          end
        end
        S_READ: if (cnt == '0) begin
          rsp_rdata <= mem_dq_in;
          mem_rd_n  <= 1'b1;
          mem_sel_n <= 1'b1;
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end else cnt <= cnt - CNT_W'(1);
        S_WTURN: if (rd_hi_cnt >= HZ_W'(HZ_CYC - 1)) begin
          mem_wr_n  <= 1'b0;
          bus_drive <= 1'b1;
          cnt       <= CNT_W'(PW_CYC - 1);
          state     <= S_WPULSE;
        end
        S_WPULSE: if (cnt == '0) begin
          mem_wr_n  <= 1'b1;
          bus_drive <= 1'b0;
          cnt       <= CNT_W'(REC_CYC - 1);
          state     <= S_WREC;
        end else cnt <= cnt - CNT_W'(1);
        S_WREC: if (cnt == '0) begin
          mem_sel_n <= 1'b1;
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end else cnt <= cnt - CNT_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && mem_wr_n && mem_rd_n && !bus_drive));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  drive_off_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> $fell(bus_drive));

  // R7
  drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> (rd_hi_cnt >= HZ_W'(HZ_CYC)));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (!bus_drive && mem_wr_n));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int CLK_NS = 20;
  localparam int T_RC = 45, T_AA = 45, T_DOE = 22, T_WC = 45;
  localparam int T_PWE = 35, T_SD = 25, T_HZ = 18;
  localparam int RD_CYC = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, bus_drive, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .bus_drive(bus_drive), .mem_dq_in(mem_dq_in),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory model
  byte unsigned mem [int];
  realtime t_addr = 0, t_rd_fall = 0, t_rd_rise = 0, t_wr_fall = 0, t_drv_rise = 0, t_sel_fall = 0;
  bit last_was_wr = 0;
  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_rd_n) t_rd_fall = $realtime;
  always @(negedge mem_wr_n) t_wr_fall = $realtime;
  always @(negedge mem_sel_n) begin t_sel_fall = $realtime; last_was_wr = 0; end
  always @(posedge mem_rd_n) if (rst_n) begin
    t_rd_rise = $realtime;
    // R2 read strobe width
    check(($realtime - t_rd_fall) >= T_DOE && ($realtime - t_rd_fall) >= T_AA, "R2",
          int'($realtime - t_rd_fall), T_AA);
  end
  always @(posedge bus_drive) begin
    t_drv_rise = $realtime;
    // R7 turnaround after read
    check(($realtime - t_rd_rise) >= T_HZ, "R7", int'($realtime - t_rd_rise), T_HZ);
  end
  always @(posedge mem_wr_n) if (rst_n) begin
    last_was_wr = 1;
    // R5 pulse width, R6 data setup
    check(($realtime - t_wr_fall) >= T_PWE, "R5", int'($realtime - t_wr_fall), T_PWE);
    check(($realtime - t_drv_rise) >= T_SD, "R6", int'($realtime - t_drv_rise), T_SD);
    if (!mem_sel_n && mem_sel) mem[int'(mem_addr)] = mem_dq_out;
  end
  always @(posedge mem_sel_n) if (rst_n) begin
    // R9 selected period
    if (last_was_wr)
      check(($realtime - t_sel_fall) >= T_WC, "R9", int'($realtime - t_sel_fall), T_WC);
    else
      check(($realtime - t_sel_fall) >= T_RC, "R9", int'($realtime - t_sel_fall), T_RC);
  end
  always begin
    #1;
    if (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n &&
        ($realtime - t_rd_fall) >= T_DOE && ($realtime - t_addr) >= T_AA)
      mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hEE;
  end

  // per-cycle port monitors
  logic [16:0] prev_addr = '0;
  bit prev_sel = 0, prev_rsp = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      // R1 reset state
      check(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !bus_drive, "R1",
            {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, bus_drive}, 5'b10110);
    end else begin
      if (req_ready)   // R1 idle
        check(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !bus_drive, "R1",
              {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, bus_drive}, 5'b10110);
      // R3
      check(req_ready == mem_sel_n, "R3", req_ready, mem_sel_n);
      // R8
      if (!mem_rd_n) check(!bus_drive && mem_wr_n, "R8", {bus_drive, mem_wr_n}, 2'b01);
      // R9 address hold
      if (prev_sel && !mem_sel_n) check(mem_addr == prev_addr, "R9", mem_addr, prev_addr);
      // R4 one-cycle pulse
      if (prev_rsp) check(!rsp_valid, "R4", rsp_valid, 0);
    end
    prev_addr = mem_addr;
    prev_sel  = !mem_sel_n;
    prev_rsp  = rsp_valid;
  end

  // scoreboard
  typedef struct { bit wr; logic [7:0] data; realtime t_acc; } item_t;
  item_t exp_q[$];
  byte unsigned ref_map [int];

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) check(0, "R4", 1, 0);
    else begin
      item_t it;
      it = exp_q.pop_front();
      if (!it.wr) begin
        int lat;
        check(rsp_rdata == it.data, "R2", rsp_rdata, it.data);
        lat = int'(($realtime - it.t_acc + CLK_NS/2) / CLK_NS);
        check(lat == RD_CYC + 1, "R4", lat, RD_CYC + 1);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    it.wr = wr;
    it.t_acc = $realtime + CLK_NS/2;
    if (wr) begin
      ref_map[int'(a)] = d;
      it.data = d;
    end else
      it.data = ref_map.exists(int'(a)) ? ref_map[int'(a)] : 8'h00;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [16:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R2 read of unwritten location
    do_req(0, 17'h00000, 8'h00);
    // R5 writes at boundary addresses
    do_req(1, 17'h00000, 8'hA5);
    do_req(1, 17'h1FFFF, 8'h3C);
    do_req(1, 17'h0AAAA, 8'hFF);
    do_req(0, 17'h1FFFF, 8'h00);
    do_req(0, 17'h00000, 8'h00);
    // R7 write directly after read, same address, then read back
    do_req(0, 17'h0AAAA, 8'h00);
    do_req(1, 17'h0AAAA, 8'h00);
    do_req(0, 17'h0AAAA, 8'h00);
    // overwrite
    do_req(1, 17'h00000, 8'h5A);
    do_req(0, 17'h00000, 8'h00);
    // mixed pattern
    lfsr = 17'h1ACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[15:0], lfsr[16] ^ lfsr[13]};
      do_req(lfsr[0], {12'h000, lfsr[7:3]}, lfsr[16:9]);
    end
    for (int i = 0; i < 32; i++) do_req(0, 17'(i), 8'h00);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule